// File: doc/BRIEF.md
# Affine Source-Coordinate Generator

This block steps through an output frame in raster order and, for every output position, works out which point of the input frame it should be sampled from. The mapping is a programmable 2×3 affine transform with signed fixed-point coefficients. Each source coordinate is handed to the sample buffer as a request over a valid/ready handshake. A request has a signed integer part and an 8-bit fraction for each axis, a flag for a point that lies outside the input frame, and a flag on the final request of the frame. Because the mapping is evaluated as the frame is walked, no precomputed coordinate table has to be streamed in.

Software writes the coefficients and the frame sizes into holding registers at any time. A `start` pulse while the block is idle copies them into the working set, so a frame always runs with one consistent transform. Alongside the generator, a second counter follows the column and row of every sample that enters the input stream. Control logic can compare it with the request coordinates to decide when a request may be served.

Top module: `affine_coord_gen`

## Requirements
- R1: After reset, `req_valid`, `busy` and `frame_done` are 0 and `in_col`/`in_row` are 0. The holding coefficients reset to the identity map: XX=YY=0x0100 and all others 0. All four frame sizes reset to 16.
- R2: After `start` is accepted, exactly OUT_W×OUT_H requests are issued. The column runs from 0 to OUT_W-1, and after its last value it returns to 0 while the row advances. Rows run from 0 to OUT_H-1.
- R3: For output column u and row v, the source x is XX·u + XY·v + XO and the source y is YX·u + YY·v + YO. Coefficients and offsets are signed Q8.8 values. The config addresses are 0=XX, 1=XY, 2=XO, 3=YX, 4=YY and 5=YO. The request carries floor(value) as a 16-bit two's-complement integer and the low 8 bits of the value as the fraction. A shear of the form y' = λ·x + y is therefore YX=λ, YY=1.
- R4: `req_oob` is 1 exactly when either source coordinate is negative, or when its integer part is at least the input width (for x) or the input height (for y).
- R5: `req_last` is 1 only on the final request of a frame. `frame_done` is 1 in the cycle that request is accepted. In the next cycle `busy` and `req_valid` are 0.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and every request field holds its value.
- R7: Config writes update only the holding registers, at addresses 0–5 for coefficients and 6=OUT_W, 7=OUT_H, 8=IN_W, 9=IN_H for sizes. A write during a frame does not change the requests of that frame, and it is used from the next accepted `start` onward.
- R8: A `start` pulse while `busy` is 1 is ignored. The frame in progress neither restarts nor grows.
- R9: On each `in_beat`, `in_col` advances by one and returns to 0 after IN_W-1. At that point `in_row` advances, and it returns to 0 after IN_H-1. Without `in_beat`, both hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a holding register |
| cfg_addr | input | 4 | Holding register address |
| cfg_data | input | 16 | Write data (Q8.8 coefficient or frame size) |
| start | input | 1 | Begin a frame when idle |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Final request accepted this cycle |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Consumer accepts the request |
| req_x_int | output | 16 | Source x, integer part |
| req_x_frac | output | 8 | Source x, fraction |
| req_y_int | output | 16 | Source y, integer part |
| req_y_frac | output | 8 | Source y, fraction |
| req_oob | output | 1 | Source point outside the input frame |
| req_last | output | 1 | Final request of the frame |
| in_beat | input | 1 | An input sample is taken this cycle |
| in_col | output | 12 | Column of the current input sample |
| in_row | output | 12 | Row of the current input sample |

## Verification
The assertions watch the handshake hold under backpressure, the end-of-frame shutdown, the freezing of the working set while a frame runs, the refusal of a second start, and the one-step motion of the input counter. They check these on every cycle. The arithmetic of the mapping, the rounding of negative values, the out-of-range decision and the exact raster order can only be shown by the bench's scenarios. Those scenarios cover identity, scaling with fractional offsets, negative shear, an offset that pushes the source point past the input edge, and a reconfiguration in the middle of a frame.

// File: rtl/affine_coord_gen.sv
module affine_coord_gen #(
  parameter int COORD_W = 12,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 8,
  parameter int INT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [COEF_W-1:0]  cfg_data,
  input  logic               start,
  output logic               busy,
  output logic               frame_done,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [INT_W-1:0]   req_x_int,
  output logic [FRAC_W-1:0]  req_x_frac,
  output logic [INT_W-1:0]   req_y_int,
  output logic [FRAC_W-1:0]  req_y_frac,
  output logic               req_oob,
  output logic               req_last,
  input  logic               in_beat,
  output logic [COORD_W-1:0] in_col,
  output logic [COORD_W-1:0] in_row
);

  localparam int SUM_W = COEF_W + COORD_W + 3;
  localparam int NCOEF = 6;
  localparam logic [COORD_W-1:0] DIM_RST = COORD_W'(16);
  localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1 << FRAC_W);

  logic signed [COEF_W-1:0] sh_c  [NCOEF];
  logic signed [COEF_W-1:0] act_c [NCOEF];
  logic [COORD_W-1:0] sh_ow, sh_oh, sh_iw, sh_ih;
  logic [COORD_W-1:0] act_ow, act_oh, act_iw, act_ih;

  logic [COORD_W-1:0] xo, yo;
  logic more, take, xo_last, yo_last, oob_x, oob_y;
  logic signed [SUM_W-1:0] sxo, syo, xs, ys;
  logic signed [SUM_W-1:0] rx, ry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) sh_c[i] <= '0;
      sh_c[0] <= ONE;
      sh_c[4] <= ONE;
      sh_ow <= DIM_RST; sh_oh <= DIM_RST; sh_iw <= DIM_RST; sh_ih <= DIM_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: sh_c[cfg_addr] <= cfg_data;
        4'd6: sh_ow <= cfg_data[COORD_W-1:0];
        4'd7: sh_oh <= cfg_data[COORD_W-1:0];
        4'd8: sh_iw <= cfg_data[COORD_W-1:0];
        4'd9: sh_ih <= cfg_data[COORD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) act_c[i] <= '0;
      act_ow <= DIM_RST; act_oh <= DIM_RST; act_iw <= DIM_RST; act_ih <= DIM_RST;
    end else if (!busy && start) begin
      for (int i = 0; i < NCOEF; i++) act_c[i] <= sh_c[i];
      act_ow <= sh_ow; act_oh <= sh_oh; act_iw <= sh_iw; act_ih <= sh_ih;
    end
  end

  assign sxo = SUM_W'(xo);
  assign syo = SUM_W'(yo);
  assign xs  = SUM_W'(act_c[0]) * sxo + SUM_W'(act_c[1]) * syo + SUM_W'(act_c[2]);
  assign ys  = SUM_W'(act_c[3]) * sxo + SUM_W'(act_c[4]) * syo + SUM_W'(act_c[5]);

  assign oob_x = xs[SUM_W-1] || (xs[SUM_W-1:FRAC_W] >= (SUM_W-FRAC_W)'(act_iw));
  assign oob_y = ys[SUM_W-1] || (ys[SUM_W-1:FRAC_W] >= (SUM_W-FRAC_W)'(act_ih));

  assign xo_last = ({1'b0, xo} + 1'b1) >= {1'b0, act_ow};
  assign yo_last = ({1'b0, yo} + 1'b1) >= {1'b0, act_oh};
  assign take    = more && (!req_valid || req_ready);
  assign frame_done = req_valid && req_ready && req_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; more <= 1'b0; xo <= '0; yo <= '0;
      req_valid <= 1'b0; rx <= '0; ry <= '0; req_oob <= 1'b0; req_last <= 1'b0;
    end else begin
      if (!busy && start) begin
        busy <= 1'b1; more <= 1'b1; xo <= '0; yo <= '0;
      end else begin
        if (take) begin
          if (xo_last) begin
            xo <= '0;
            if (yo_last) more <= 1'b0;
            else         yo <= yo + 1'b1;
          end else begin
            xo <= xo + 1'b1;
          end
        end
        if (frame_done) busy <= 1'b0;
      end
      if (take) begin
        req_valid <= 1'b1;
        rx <= xs; ry <= ys;
        req_oob  <= oob_x || oob_y;
        req_last <= xo_last && yo_last;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  assign req_x_int  = rx[FRAC_W +: INT_W];
  assign req_x_frac = rx[FRAC_W-1:0];
  assign req_y_int  = ry[FRAC_W +: INT_W];
  assign req_y_frac = ry[FRAC_W-1:0];

  logic col_wrap, row_wrap;
  assign col_wrap = ({1'b0, in_col} + 1'b1) >= {1'b0, sh_iw};
  assign row_wrap = ({1'b0, in_row} + 1'b1) >= {1'b0, sh_ih};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_col <= '0; in_row <= '0;
    end else if (in_beat) begin
      if (col_wrap) begin
        in_col <= '0;
        in_row <= row_wrap ? '0 : in_row + 1'b1;
      end else begin
        in_col <= in_col + 1'b1;
      end
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(rx) && $stable(ry) && $stable(req_oob) && $stable(req_last)); // R6
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R5
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy && !req_valid); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_c[0]) && $stable(act_c[2]) && $stable(act_c[5]) && $stable(act_ow) && $stable(act_iw)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !frame_done |=> busy); // R8
  AST_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_beat |=> (in_col == '0) || (in_col == $past(in_col) + 1'b1)); // R9
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_beat |=> $stable(in_col) && $stable(in_row)); // R9

endmodule

// File: tb/test_affine_coord_gen.sv
`timescale 1ns/1ps
module test_affine_coord_gen;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [3:0] cfg_addr = 0; logic [15:0] cfg_data = 0;
  logic start = 0, busy, frame_done, req_valid, req_ready = 0;
  logic [15:0] req_x_int, req_y_int; logic [7:0] req_x_frac, req_y_frac;
  logic req_oob, req_last, in_beat = 0;
  logic [11:0] in_col, in_row;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int b_c[6] = '{256, 0, 0, 0, 256, 0};
  int b_ow = 16, b_oh = 16, b_iw = 16, b_ih = 16;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  affine_coord_gen i_affine_coord_gen (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wcfg(input int addr, input int val);
    @(negedge clk); cfg_we = 1; cfg_addr = addr[3:0]; cfg_data = val[15:0];
    @(negedge clk); cfg_we = 0;
    if (addr < 6) b_c[addr] = $signed(val[15:0]);
    else if (addr == 6) b_ow = val; else if (addr == 7) b_oh = val;
    else if (addr == 8) b_iw = val; else if (addr == 9) b_ih = val;
  endtask

  task automatic run_frame(input bit bp, input int mid_k, input int mid_val, input string tag);
    int c[6]; int w, h, iw, ih, idx, n; bit mid_on; bit done_seen;
    foreach (c[i]) c[i] = b_c[i];
    w = b_ow; h = b_oh; iw = b_iw; ih = b_ih; n = w * h; idx = 0; mid_on = 0; done_seen = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int t = 0; t < 20000 && idx < n; t++) begin
      @(negedge clk);
      if (mid_on) begin cfg_we = 0; start = 0; mid_on = 0; end
      if (idx == mid_k) begin
        cfg_we = 1; cfg_addr = 4'd2; cfg_data = mid_val[15:0]; start = 1; mid_on = 1;
        b_c[2] = $signed(mid_val[15:0]); mid_k = -1;
      end
      req_ready = bp ? ((t % 3) != 1) : 1'b1;
      #1;
      if (req_valid && req_ready) begin
        longint ex, ey, exi, eyi; bit eo, ok;
        int u, v;
        u = idx % w; v = idx / w;
        ex = longint'(c[0]) * u + longint'(c[1]) * v + c[2];
        ey = longint'(c[3]) * u + longint'(c[4]) * v + c[5];
        exi = ex >>> 8; eyi = ey >>> 8;
        eo = (ex < 0) || (exi >= iw) || (ey < 0) || (eyi >= ih);
        ok = ($signed(req_x_int) == exi) && (req_x_frac == (ex & 255)) &&
             ($signed(req_y_int) == eyi) && (req_y_frac == (ey & 255));
        chk(ok, {tag, " R2/R3 coord"}, "x_fix", {$signed(req_x_int), req_x_frac}, ex);
        if (!ok) $display("FAIL %s R3 y_fix actual=%0d expected=%0d", tag, $signed({req_y_int, req_y_frac}), ey);
        chk(req_oob == eo, {tag, " R4 oob"}, "oob", req_oob, eo);
        chk(req_last == (idx == n - 1), {tag, " R5 last"}, "last", req_last, idx == n - 1);
        if (idx == n - 1) done_seen = frame_done;
        idx++;
      end
    end
    if (mid_on) begin @(negedge clk); cfg_we = 0; start = 0; end
    chk(idx == n, {tag, " R2 count"}, "requests", idx, n);
    chk(done_seen, {tag, " R5 frame_done"}, "frame_done", done_seen, 1);
    @(negedge clk); req_ready = 0; #1;
    chk(!busy && !req_valid, {tag, " R5 idle"}, "busy|valid", busy | req_valid, 0);
    repeat (3) @(negedge clk);
    chk(!req_valid, {tag, " R8 no restart"}, "req_valid", req_valid, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(!req_valid && !busy && !frame_done, "R1", "ctl", {req_valid, busy, frame_done}, 0);
    chk(in_col == 0 && in_row == 0, "R1", "in_pos", {in_col, in_row}, 0);
  endtask

  task automatic t_identity;
    wcfg(6, 8); wcfg(7, 4); wcfg(8, 8); wcfg(9, 4);
    run_frame(0, -1, 0, "identity");
  endtask

  task automatic t_scale;
    wcfg(0, 128); wcfg(2, 64); wcfg(4, 128); wcfg(5, 16'hFFE0);
    wcfg(6, 6); wcfg(7, 3); wcfg(8, 4); wcfg(9, 2);
    run_frame(1, -1, 0, "scale R6");
  endtask

  task automatic t_shear;
    wcfg(0, 256); wcfg(1, 0); wcfg(2, 3 * 256); wcfg(3, 16'hFFC0); wcfg(4, 256); wcfg(5, 0);
    wcfg(6, 8); wcfg(7, 5); wcfg(8, 8); wcfg(9, 5);
    run_frame(1, -1, 0, "shear");
  endtask

  task automatic t_midframe;
    wcfg(2, 0); wcfg(3, 0); wcfg(6, 4); wcfg(7, 3); wcfg(8, 4); wcfg(9, 3);
    run_frame(0, 5, 256, "midcfg R7 R8");
    run_frame(1, -1, 0, "nextframe R7");
  endtask

  task automatic t_input;
    wcfg(8, 5); wcfg(9, 3);
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk); in_beat = 1;
      @(negedge clk); in_beat = 0; #1;
      chk(in_col == k % 5 && in_row == (k / 5) % 3, "R9 beat", "col_row",
          {in_col, in_row}, {12'(k % 5), 12'((k / 5) % 3)});
    end
    repeat (3) @(negedge clk); #1;
    chk(in_col == 2 && in_row == 0, "R9 hold", "col_row", {in_col, in_row}, {12'd2, 12'd0});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_identity();
    t_scale();
    t_shear();
    t_midframe();
    t_input();
    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    finish_run();
  end
endmodule